// File: doc/BRIEF.md
# Byte-Masked Read Parity Checker

This block sits on the read side of a 64-bit data bus that is split into eight byte lanes, each with its own parity bit. When a read transfer delivers data, the block checks every lane that the transfer actually uses. For each of those lanes it tests the eight data bits together with that lane's parity bit, which must hold an even number of ones. It then gives a one-cycle, active-low verdict for the whole transfer.

Lanes whose active-low byte enable is deasserted are left out of the check, so any mix of enabled lanes is legal. A separate active-low parity-enable input decides whether a detected error drives the summary flag. A registered per-lane error vector is available for debug and reports the same transfer in the same cycle as the flag.

The input side is a plain valid strobe with no ready. Every cycle in which `rd_valid` is high is accepted as one read transfer. There is no back-pressure, and results come out at a fixed latency of one clock.

Top module: `rd_parity_check`

## Requirements
- R1: Lane i is made of bits [8i+7:8i] of `rd_data` plus `rd_par[i]`. The lane is in error when those nine bits hold an odd number of ones. A flip of an even number of bits inside one lane is not detected.
- R2: A lane whose `lane_en_n[i]` is 1 never shows an error in `lane_err[i]` and never contributes to `chk_n`, whatever its data and parity.
- R3: A read with all eight bits of `lane_en_n` at 1 yields `chk_n` = 1 and `lane_err` = 0.
- R4: `chk_n` is 0 in the cycle after a cycle with `rd_valid` = 1 exactly when `par_en_n` was 0 and at least one enabled lane was in error. Otherwise it is 1.
- R5: With `par_en_n` = 1 during a read, `chk_n` stays 1. `lane_err` still reports the enabled lanes in error.
- R6: In the cycle after a cycle with `rd_valid` = 0, `chk_n` is 1 and `lane_err` is 0. The flag is therefore a single-cycle pulse for each read.
- R7: While `rst_n` is 0, `chk_n` is 1 and `lane_err` is 0.
- R8: Reads on consecutive cycles each produce their own result, one cycle later, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read data present on this cycle |
| rd_data | input | 64 | Read data, lane i at bits [8i+7:8i] |
| rd_par | input | 8 | Parity bit per lane, bit i covers lane i |
| lane_en_n | input | 8 | Active-low byte enables, bit i for lane i |
| par_en_n | input | 1 | Active-low enable for error reporting on `chk_n` |
| chk_n | output | 1 | Active-low parity error flag, one cycle after the read |
| lane_err | output | 8 | Per-lane error vector, registered with `chk_n` |

## Verification
The assertions check four things on every cycle. A low flag always follows a read made with reporting enabled, and it always comes with a non-empty error vector. No disabled lane ever appears in the vector. An idle cycle clears both outputs on the next cycle. Only the bench scenarios can show that the parity rule itself is right: odd-weight lanes are caught and even-weight multi-bit flips pass. They also show that the correct lanes are named and that back-to-back reads keep their own results.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  localparam int LANES_DEF  = 8;
  localparam int LANE_W_DEF = 8;

  // Odd weight over a lane plus its parity bit marks a parity fault.
  function automatic logic odd_weight(input logic [LANE_W_DEF:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/rpc_lane_check.sv
module rpc_lane_check #(
  parameter int W = rpc_pkg::LANE_W_DEF
) (
  input  logic [W-1:0] bits,
  input  logic         par_bit,
  input  logic         en_n,
  output logic         err
);
  logic odd;

  always_comb begin
    odd = ^{bits, par_bit};
    err = odd & ~en_n;
  end
endmodule

// File: rtl/rpc_result_reg.sv
module rpc_result_reg #(
  parameter int LANES = rpc_pkg::LANES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic             par_en_n,
  input  logic [LANES-1:0] en_n,
  input  logic [LANES-1:0] raw_err,
  output logic             chk_n,
  output logic [LANES-1:0] lane_err
);
  logic any_err;

  always_comb any_err = |raw_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_n    <= 1'b1;
      lane_err <= '0;
    end else if (rd_valid) begin
      lane_err <= raw_err;
      chk_n    <= ~(any_err & ~par_en_n);
    end else begin
      lane_err <= '0;
      chk_n    <= 1'b1;
    end
  end

  // R4: a low flag is always backed by a recorded lane error
  p_flag_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_n |-> (lane_err != '0));

  // R5: a low flag needs reporting enabled on the read that caused it
  p_flag_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_n |-> !$past(par_en_n));

  // R2: a lane disabled on the read never shows up in the vector
  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> ((lane_err & $past(en_n)) == '0));

  // R6: an idle cycle clears both outputs on the next cycle
  p_idle_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> (chk_n && lane_err == '0));
endmodule

// File: rtl/rd_parity_check.sv
module rd_parity_check #(
  parameter int LANES  = rpc_pkg::LANES_DEF,
  parameter int LANE_W = rpc_pkg::LANE_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_valid,
  input  logic [LANES*LANE_W-1:0] rd_data,
  input  logic [LANES-1:0]        rd_par,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic                    par_en_n,
  output logic                    chk_n,
  output logic [LANES-1:0]        lane_err
);
  localparam int DATA_W = LANES * LANE_W;

  logic [LANES-1:0] raw_err;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    rpc_lane_check #(.W(LANE_W)) u_lane (
      .bits   (rd_data[i*LANE_W +: LANE_W]),
      .par_bit(rd_par[i]),
      .en_n   (lane_en_n[i]),
      .err    (raw_err[i])
    );
  end

  rpc_result_reg #(.LANES(LANES)) u_res (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_valid(rd_valid),
    .par_en_n(par_en_n),
    .en_n    (lane_en_n),
    .raw_err (raw_err),
    .chk_n   (chk_n),
    .lane_err(lane_err)
  );

  // R7: reset leaves the flag high and the vector empty on the next cycle
  p_reset_state_r7: assert property (@(posedge clk)
    !rst_n |=> (chk_n && lane_err == '0));

  // R3: a read with every lane disabled cannot flag
  p_no_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && &lane_en_n) |=> (chk_n && lane_err == '0));

  initial begin
    if (DATA_W != LANES * LANE_W) $error("bus width mismatch");
  end
endmodule

// File: tb/rd_parity_check_bench.sv
module rd_parity_check_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic [63:0] rd_data = '0;
  logic [7:0]  rd_par = '0;
  logic [7:0]  lane_en_n = '1;
  logic        par_en_n = 1'b0;
  logic        chk_n;
  logic [7:0]  lane_err;

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  rd_parity_check u_rd_parity_check (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_par(rd_par), .lane_en_n(lane_en_n), .par_en_n(par_en_n),
    .chk_n(chk_n), .lane_err(lane_err)
  );

  function automatic logic [7:0] good_par(input logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = ^d[i*8 +: 8];
    return p;
  endfunction

  function automatic logic [8:0] model(input logic v, input logic [63:0] d,
                                       input logic [7:0] p, input logic [7:0] en_n,
                                       input logic pen_n);
    logic [7:0] e;
    e = '0;
    if (v)
      for (int i = 0; i < 8; i++)
        e[i] = ($countones({d[i*8 +: 8], p[i]}) % 2 == 1) && !en_n[i];
    return {~(v && !pen_n && (e != 0)), e};
  endfunction

  task automatic drive(input logic v, input logic [63:0] d, input logic [7:0] p,
                       input logic [7:0] en_n, input logic pen_n, input string tag);
    @(negedge clk);
    rd_valid = v; rd_data = d; rd_par = p; lane_en_n = en_n; par_en_n = pen_n;
    exp_q.push_back(model(v, d, p, en_n, pen_n));
    tag_q.push_back(tag);
  endtask

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act chk_n=%b err=%h exp chk_n=%b err=%h",
               tag, act[8], act[7:0], exp[8], exp[7:0]);
    end
  endtask

  // Monitor: results settle one edge after the driving negedge.
  initial begin
    forever begin
      @(posedge clk); #2;
      if (rst_n && exp_q.size() > 0) check(tag_q.pop_front(), {chk_n, lane_err}, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [7:0]  p;
    // inputs carry a lane error during reset to show it is held off
    rd_valid = 1'b1; rd_data = 64'h1; rd_par = '0; lane_en_n = '0;
    repeat (3) @(posedge clk);
    #2 check("R7 reset", {chk_n, lane_err}, 9'h100);
    @(negedge clk); rst_n = 1'b1; rd_valid = 1'b0;

    d = 64'h0123_4567_89AB_CDEF; p = good_par(d);
    drive(1, d, p, 8'h00, 0, "R1 clean");
    drive(1, d ^ 64'h0000_0000_0800_0000, p, 8'h00, 0, "R1 single flip lane3");
    drive(1, d ^ 64'h0000_0300_0000_0000, p, 8'h00, 0, "R1 double flip lane5");
    drive(1, d ^ 64'h8000_0000_0000_0000, p ^ 8'h01, 8'h00, 0, "R1 lanes 0 and 7");
    drive(1, d ^ 64'h0000_0000_0004_0000, p, 8'h04, 0, "R2 error in disabled lane2");
    drive(1, d ^ 64'h0101_0101_0101_0101, p, 8'hFF, 0, "R3 no lanes enabled");
    drive(1, d ^ 64'h0000_0000_0000_0100, p, 8'h00, 1, "R5 reporting off");
    drive(0, d ^ 64'h0101_0101_0101_0101, p, 8'h00, 0, "R6 idle with bad data");
    drive(1, d ^ 64'h0000_0010_0000_0000, p, 8'h00, 0, "R8 back to back a");
    drive(1, d, p, 8'h00, 0, "R8 back to back b");
    drive(1, d ^ 64'h0000_0000_0000_0001, p, 8'h0E, 0, "R4 mixed mask");
    drive(0, d, p, 8'h00, 0, "R6 pulse ends");
    for (int k = 0; k < 40; k++) begin
      d = {$urandom, $urandom};
      p = good_par(d) ^ 8'($urandom);
      drive(1'($urandom), d, p, 8'($urandom), 1'($urandom % 4 == 0), "R4 random");
    end
    drive(0, '0, '0, '1, 0, "R6 drain");
    @(negedge clk); @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule